// File: doc/BRIEF.md
# Threshold Stochastic Significand Rounder

This block narrows a fixed-point significand by a number of low bits chosen at run time. The decision to round up is stochastic: a random integer supplied with each operand is compared against a scaled copy of the discarded fraction. The block is meant to sit at the very last step of a datapath, where a wide result is stored into a narrow format. The arithmetic that produced the wide value is not touched. Exponent handling, special values and the random source are left to the surrounding logic.

Three decision rules can be selected per operand, each with a different balance of bias and cost. The first truncates the scaled fraction to r bits. The second resolves it to r+1 bits, which gives twice as many decision subintervals. The third rounds the scaled fraction to nearest, ties to even, at r bits. Operands arrive on a valid/ready stream and results leave from a single output register. A result whose round-up overflows the kept field raises a carry flag, so that the caller can increment its exponent.

Top module: `stoch_rounder`

## Requirements
- R1: An operand is accepted on a clock edge where `in_valid` and `in_ready` are both high. Its result appears with `out_valid` high after that edge. `in_ready` is high whenever the output register is empty or `out_ready` is high. `in_drop` must lie in 1..IN_W-1.
- R2: With `in_mode` = 0, let F be the discarded bits `in_sig[d-1:0]` read as a fraction of one output unit, and let fa = floor(2^r·F). The result rounds up exactly when fa + `in_rand` >= 2^r. Over all 2^r random values, fa of them round up.
- R3: With `in_mode` = 1, let fb = floor(2^(r+1)·F). The result rounds up exactly when fb + 2·`in_rand` + 1 >= 2^(r+1). Over all random values, floor((fb+1)/2) of them round up.
- R4: With `in_mode` = 2, let fc be 2^r·F rounded to nearest with ties to even; fc may equal 2^r. The result rounds up exactly when fc + `in_rand` >= 2^r. Over all random values, fc of them round up.
- R5: When the discarded bits are all zero, `out_sig` equals `in_sig >> in_drop` with `out_carry` low, for every random value and every mode.
- R6: When a round-up makes the kept value reach 2^(IN_W-d), `out_carry` is high and `out_sig` equals 2^(IN_W-d-1). Otherwise `out_carry` is low.
- R7: While `out_valid` is high and `out_ready` is low, `in_ready` is low, and `out_sig`, `out_carry` and `out_valid` hold their values.
- R8: `in_mode` = 3 behaves exactly like mode 0.
- R9: While `rst` is high, and in the first cycle after it falls, `out_valid` is low and `in_ready` is high.
- R10: Unless `out_carry` is high, `out_sig` equals either `in_sig >> in_drop` or that value plus one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand present |
| in_ready | output | 1 | Operand can be taken |
| in_sig | input | IN_W | Wide significand |
| in_rand | input | R_W | Random integer, 0..2^r-1 |
| in_mode | input | 2 | Decision rule: 0 floor, 1 half-step, 2 nearest-even, 3 as 0 |
| in_drop | input | $clog2(IN_W) | Number of low bits to discard |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Result taken |
| out_sig | output | IN_W | Rounded significand, right-aligned |
| out_carry | output | 1 | Round-up overflowed the kept field |

## Verification
The hardest behaviour to observe from the ports is the exact round-up count of each rule. A single operand shows only one coin flip, and the rules differ by just one random value in a few cases. The bench therefore holds one significand fixed and sweeps every random value from 0 to 2^r-1, then compares the number of round-ups with a count it derives by integer arithmetic from the discarded bits. The chosen fractions cover several cases: a discard narrower than r, a discard of exactly r+1 bits, nearest-even ties on both parities, a fraction so close to one that the nearest-even rule rounds up for every random value, and a kept field of all ones so that the carry shows.

// File: rtl/sr_pkg.sv
package sr_pkg;

    typedef enum logic [1:0] {
        MODE_FLOOR    = 2'd0,
        MODE_HALFSTEP = 2'd1,
        MODE_NEAREST  = 2'd2,
        MODE_SPARE    = 2'd3
    } sr_mode_e;

    typedef struct packed {
        logic up_floor;
        logic up_half;
        logic up_near;
    } sr_votes_t;

endpackage

// File: rtl/sr_frac_align.sv
module sr_frac_align #(
    parameter int IN_W = 24,
    parameter int R_W  = 8,
    parameter int DW   = $clog2(IN_W)
) (
    input  logic [IN_W-1:0] sig,
    input  logic [DW-1:0]   drop,
    output logic [IN_W-1:0] kept,
    output logic [R_W:0]    frac_hi,
    output logic            sticky
);
    localparam int EXT_W = IN_W + R_W + 1;
    localparam int SHW   = $clog2(EXT_W + 1);

    logic [IN_W-1:0]  lowmask;
    logic [EXT_W-1:0] frac_ext;
    logic [EXT_W-1:0] aligned;
    logic [SHW-1:0]   shamt;

    always_comb begin
        lowmask  = ~({IN_W{1'b1}} << drop);
        frac_ext = {{(EXT_W-IN_W){1'b0}}, sig & lowmask};
        shamt    = SHW'(EXT_W) - SHW'(drop);
        aligned  = frac_ext << shamt;
        kept     = sig >> drop;
        frac_hi  = aligned[EXT_W-1 -: R_W+1];
        sticky   = |aligned[EXT_W-R_W-2:0];
    end
endmodule

// File: rtl/sr_decide.sv
module sr_decide
    import sr_pkg::*;
#(
    parameter int R_W = 8
) (
    input  logic [R_W:0]   frac_hi,
    input  logic           sticky,
    input  logic [R_W-1:0] rnd,
    input  logic [1:0]     mode,
    output logic           up
);
    logic [R_W-1:0] fa;
    logic [R_W:0]   sum_a;
    logic [R_W+1:0] sum_b;
    logic           near_inc;
    logic [R_W:0]   fc;
    logic [R_W+1:0] sum_c;
    sr_votes_t      votes;

    always_comb begin
        fa       = frac_hi[R_W:1];
        sum_a    = {1'b0, fa} + {1'b0, rnd};
        sum_b    = {1'b0, frac_hi} + {1'b0, rnd, 1'b1};
        near_inc = frac_hi[0] & (sticky | fa[0]);
        fc       = {1'b0, fa} + {{R_W{1'b0}}, near_inc};
        sum_c    = {1'b0, fc} + {2'b00, rnd};

        votes.up_floor = sum_a[R_W];
        votes.up_half  = sum_b[R_W+1];
        votes.up_near  = |sum_c[R_W+1:R_W];

        unique case (sr_mode_e'(mode))
            MODE_HALFSTEP: up = votes.up_half;
            MODE_NEAREST:  up = votes.up_near;
            default:       up = votes.up_floor;
        endcase
    end
endmodule

// File: rtl/sr_increment.sv
module sr_increment #(
    parameter int IN_W = 24,
    parameter int DW   = $clog2(IN_W)
) (
    input  logic [IN_W-1:0] kept,
    input  logic [DW-1:0]   drop,
    input  logic            up,
    output logic [IN_W-1:0] sig_out,
    output logic            carry
);
    logic [IN_W:0] sum;
    logic [IN_W:0] limit;

    always_comb begin
        sum     = {1'b0, kept} + {{IN_W{1'b0}}, up};
        limit   = {1'b1, {IN_W{1'b0}}} >> drop;
        carry   = (sum == limit);
        sig_out = carry ? limit[IN_W:1] : sum[IN_W-1:0];
    end
endmodule

// File: rtl/stoch_rounder.sv
module stoch_rounder #(
    parameter  int IN_W = 24,
    parameter  int R_W  = 8,
    localparam int DW   = $clog2(IN_W)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    output logic            in_ready,
    input  logic [IN_W-1:0] in_sig,
    input  logic [R_W-1:0]  in_rand,
    input  logic [1:0]      in_mode,
    input  logic [DW-1:0]   in_drop,
    output logic            out_valid,
    input  logic            out_ready,
    output logic [IN_W-1:0] out_sig,
    output logic            out_carry
);
    logic [IN_W-1:0] kept;
    logic [R_W:0]    frac_hi;
    logic            sticky;
    logic            up;
    logic [IN_W-1:0] rounded;
    logic            carry;

    sr_frac_align #(.IN_W(IN_W), .R_W(R_W), .DW(DW)) u_align (
        .sig     (in_sig),
        .drop    (in_drop),
        .kept    (kept),
        .frac_hi (frac_hi),
        .sticky  (sticky)
    );

    sr_decide #(.R_W(R_W)) u_decide (
        .frac_hi (frac_hi),
        .sticky  (sticky),
        .rnd     (in_rand),
        .mode    (in_mode),
        .up      (up)
    );

    sr_increment #(.IN_W(IN_W), .DW(DW)) u_inc (
        .kept    (kept),
        .drop    (in_drop),
        .up      (up),
        .sig_out (rounded),
        .carry   (carry)
    );

    assign in_ready = !out_valid || out_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_sig   <= '0;
            out_carry <= 1'b0;
        end else if (in_ready) begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_sig   <= rounded;
                out_carry <= carry;
            end
        end
    end
endmodule

// File: rtl/stoch_rounder_chk.sv
module stoch_rounder_chk #(
    parameter  int IN_W = 24,
    parameter  int R_W  = 8,
    localparam int DW   = $clog2(IN_W)
) (
    input logic            clk,
    input logic            rst,
    input logic            in_valid,
    input logic            in_ready,
    input logic [IN_W-1:0] in_sig,
    input logic [R_W-1:0]  in_rand,
    input logic [DW-1:0]   in_drop,
    input logic            out_valid,
    input logic            out_ready,
    input logic [IN_W-1:0] out_sig,
    input logic            out_carry
);
    logic            take;
    logic [IN_W-1:0] trunc;
    logic            exact;

    always_comb begin
        take  = in_valid && in_ready;
        trunc = in_sig >> in_drop;
        exact = ((in_sig & ~({IN_W{1'b1}} << in_drop)) == '0);
    end

    p_reset_r9: assert property (@(posedge clk) rst |=> !out_valid);

    p_accept_r1: assert property (@(posedge clk) disable iff (rst)
        take |=> out_valid);

    p_empty_ready_r1: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> in_ready);

    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_sig) && $stable(out_carry)));

    p_stall_r7: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |-> !in_ready);

    p_exact_r5: assert property (@(posedge clk) disable iff (rst)
        (take && exact) |=> (!out_carry && out_sig == $past(trunc)));

    p_carry_shape_r6: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_carry) |-> ($countones(out_sig) == 1));

    p_range_r10: assert property (@(posedge clk) disable iff (rst)
        take |=> (out_carry || out_sig == $past(trunc) || out_sig == $past(trunc) + IN_W'(1)));

endmodule

bind stoch_rounder stoch_rounder_chk #(.IN_W(IN_W), .R_W(R_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_sig    (in_sig),
    .in_rand   (in_rand),
    .in_drop   (in_drop),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_sig   (out_sig),
    .out_carry (out_carry)
);

// File: tb/sim_stoch_rounder.sv
module sim_stoch_rounder;
    localparam int CLK_P = 10;
    localparam int IN_W  = 24;
    localparam int R_W   = 8;
    localparam int DW    = $clog2(IN_W);
    localparam int NR    = 1 << R_W;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            in_valid = 1'b0;
    logic            in_ready;
    logic [IN_W-1:0] in_sig = '0;
    logic [R_W-1:0]  in_rand = '0;
    logic [1:0]      in_mode = 2'd0;
    logic [DW-1:0]   in_drop = DW'(1);
    logic            out_valid;
    logic            out_ready = 1'b1;
    logic [IN_W-1:0] out_sig;
    logic            out_carry;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_P/2) clk = ~clk;

    stoch_rounder #(.IN_W(IN_W), .R_W(R_W)) u0 (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_ready(in_ready),
        .in_sig(in_sig), .in_rand(in_rand), .in_mode(in_mode), .in_drop(in_drop),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_sig(out_sig), .out_carry(out_carry)
    );

    task automatic check(input string req, input bit ok, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // one operand in, one result sampled at the following falling edge
    task automatic xfer(input logic [IN_W-1:0] s, input int d, input int m, input int r);
        @(negedge clk);
        in_sig   = s;
        in_drop  = DW'(d);
        in_mode  = 2'(m);
        in_rand  = R_W'(r);
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // Sweep every random value; compare each result and the round-up count.
    task automatic sweep(input string req, input logic [IN_W-1:0] s, input int d, input int m);
        longint f, fa, fb, fc, rem, half, trunc, lim, exp_cnt, thr;
        int ups, bad, valid_bad;
        longint first_act, first_exp;
        f     = longint'(s) & ((longint'(1) << d) - 1);
        fa    = (f << R_W) >> d;
        fb    = (f << (R_W + 1)) >> d;
        rem   = (f << R_W) - (fa << d);
        half  = longint'(1) << (d - 1);
        fc    = fa + (((rem > half) || (rem == half && fa[0])) ? 1 : 0);
        trunc = longint'(s) >> d;
        lim   = longint'(1) << (IN_W - d);
        case (m)
            1:       exp_cnt = (fb + 1) / 2;
            2:       exp_cnt = fc;
            default: exp_cnt = fa;
        endcase
        ups = 0; bad = 0; valid_bad = 0; first_act = 0; first_exp = 0;
        for (int r = 0; r < NR; r++) begin
            bit up_e;
            longint e_sig;
            bit e_car;
            case (m)
                1:       up_e = (fb + 2 * r + 1) >= 2 * NR;
                2:       up_e = (fc + r) >= NR;
                default: up_e = (fa + r) >= NR;
            endcase
            thr   = trunc + (up_e ? 1 : 0);
            e_car = (thr == lim);
            e_sig = e_car ? (lim >> 1) : thr;
            xfer(s, d, m, r);
            if (!out_valid) valid_bad++;
            if (out_carry || longint'(out_sig) != trunc) ups++;
            if (longint'(out_sig) != e_sig || out_carry != e_car) begin
                if (bad == 0) begin
                    first_act = longint'(out_sig) | (longint'(out_carry) << IN_W);
                    first_exp = e_sig | (longint'(e_car) << IN_W);
                end
                bad++;
            end
        end
        check({req, " R1 valid after accept"}, valid_bad == 0, valid_bad, 0);
        check({req, " per-value result"}, bad == 0, first_act, first_exp);
        check({req, " round-up count"}, ups == exp_cnt, ups, exp_cnt);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R9 out_valid in reset", out_valid == 1'b0, out_valid, 0);
        check("R9 in_ready in reset", in_ready == 1'b1, in_ready, 1);
        rst = 1'b0;
        @(negedge clk);
        check("R9 out_valid after reset", out_valid == 1'b0, out_valid, 0);
        check("R9 in_ready after reset", in_ready == 1'b1, in_ready, 1);
    endtask

    task automatic t_floor();
        sweep("R2 floor d=12", 24'hA5C371, 12, 0);
        sweep("R2 floor d=3", 24'h000035, 3, 0);
        sweep("R2 floor d=1", 24'h000009, 1, 0);
        sweep("R2 floor tie odd", 24'h00400E, 10, 0);
    endtask

    task automatic t_half();
        sweep("R3 half d=12", 24'hA5C371, 12, 1);
        sweep("R3 half d=9", 24'h000301, 9, 1);
        sweep("R3 half tie odd", 24'h00400E, 10, 1);
        sweep("R3 half d=1", 24'h000009, 1, 1);
    endtask

    task automatic t_near();
        sweep("R4 near d=12", 24'hA5C371, 12, 2);
        sweep("R4 near tie odd", 24'h00400E, 10, 2);
        sweep("R4 near tie even", 24'h004012, 10, 2);
        sweep("R4 near d=9 tie", 24'h000301, 9, 2);
        sweep("R4 near d=3", 24'h000035, 3, 2);
    endtask

    task automatic t_exact();
        sweep("R5 exact floor", 24'h123400, 8, 0);
        sweep("R5 exact half", 24'h123400, 8, 1);
        sweep("R5 exact near", 24'h123400, 8, 2);
    endtask

    task automatic t_carry();
        // nearest-even fraction rounds to 2^r: every random value rounds up and overflows
        sweep("R6 carry near all-up", 24'hFFFFFF, 10, 2);
        sweep("R6 carry floor", 24'hFFFFFF, 10, 0);
        xfer(24'hFFFFFF, 10, 0, 0);
        check("R6 no carry when rounded down", out_carry == 1'b0, out_carry, 0);
        xfer(24'hFFFFFF, 10, 0, 255);
        check("R6 carry value", out_carry && out_sig == 24'h002000, out_sig, 24'h002000);
    endtask

    task automatic t_spare();
        sweep("R8 spare code", 24'hA5C371, 12, 3);
        sweep("R8 spare tie", 24'h00400E, 10, 3);
    endtask

    task automatic t_backpressure();
        @(negedge clk);
        out_ready = 1'b0;
        in_sig = 24'h000100; in_drop = DW'(8); in_mode = 2'd0; in_rand = '0;
        in_valid = 1'b1;
        @(negedge clk);
        check("R7 first result", out_valid && out_sig == 24'h1, out_sig, 1);
        in_sig = 24'h000200;
        check("R7 in_ready low while stalled", in_ready == 1'b0, in_ready, 0);
        @(negedge clk);
        @(negedge clk);
        check("R7 result held", out_valid && out_sig == 24'h1 && !out_carry, out_sig, 1);
        check("R7 still stalled", in_ready == 1'b0, in_ready, 0);
        out_ready = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check("R1 next result after release", out_valid && out_sig == 24'h2, out_sig, 2);
        @(negedge clk);
        check("R1 drains", out_valid == 1'b0, out_valid, 0);
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        #(CLK_P * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_floor();
        t_half();
        t_near();
        t_exact();
        t_carry();
        t_spare();
        t_backpressure();
        finish_run();
    end
endmodule